// File: doc/BRIEF.md
# Serial Configuration Port for an Integer-N Synthesizer

This block is the programming front end of an integer-N frequency synthesizer. It takes a slow three-wire serial stream (serial clock, serial data, main-word strobe) and a second strobe that steers bits into a separate control byte. It also decodes the latched words into the divider settings and the control flags that the rest of the synthesizer uses. A direct-select input bypasses the serial path and takes the divider settings from parallel pins.

The serial clock and both strobes arrive asynchronously. Each one passes through a two-flop synchronizer into a system clock that runs at least four times faster than the serial clock, and the block acts on edges detected there. A 21-bit shift register collects the main word, and a 20-bit holding latch keeps the active divider values. An 8-bit shift register collects the control byte, and a buffer register keeps its active copy. The control flags act only while the active-low enable input is low. The data-out pin shows one of three internal timing signals, picked by a fixed priority.

Top module: `synth_cfg_port`

## Requirements
- R1: After reset, both latches and the control buffer are zero. In serial mode the divider outputs, `pre_en`, all flags and `dout` read zero.
- R2: While `e_wr` and `s_wr` are both low, every `sclk` rising edge shifts `sdata` into the 21-bit main register, first bit as MSB. First to last, the bits are: r[5], r[4], m[8], m[7], prescaler-enable, m[6:0] (MSB first), r[3:0], a[3:0], and then one address bit.
- R3: A rising edge of `s_wr` copies the main register into the holding latch, which drives `m_val`, `a_val`, `r_val` and `pre_en`. Shifting alone leaves those outputs unchanged.
- R4: If the address bit (the last bit shifted in) is 1, the transfer does not happen and the outputs keep their previous values.
- R5: While `e_wr` is high and `s_wr` is low, `sclk` rising edges shift `sdata` into the 8-bit control register. While `s_wr` is high, `sclk` shifts neither register.
- R6: A falling edge of `e_wr` copies the control register into the buffer. Control bit k is the k-th bit shifted in, counting from 0.
- R7: While `enh_n` is high, `pwr_down`, `cnt_load`, `lock_det_off` and `dout` are all 0, whatever the buffer holds.
- R8: Control bit 3 drives `pwr_down` and control bit 7 drives `lock_det_off`. Both are active high.
- R9: While control bit 4 (`cnt_load`) is active, the holding latch follows the main register on every system clock, with no `s_wr` edge. A word whose address bit is 1 is still refused.
- R10: `dout` is `fp_in` if bit 2 is set, otherwise `msel_in` if bit 5 is set, otherwise `fc_in` if bit 6 is set, otherwise 0. Bits 0 and 1 are reserved and affect no output.
- R11: With `direct_sel` high, `m_val`, `a_val`, `r_val` and `pre_en` come from the parallel pins. With it low, they come from the holding latch.
- R12: A rising edge of `s_wr` and a falling edge of `e_wr` in the same synchronized cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Serial clock, asynchronous |
| sdata | input | 1 | Serial data |
| s_wr | input | 1 | Main-word strobe; rising edge transfers |
| e_wr | input | 1 | Control-byte steer; falling edge captures |
| enh_n | input | 1 | Control flag enable, active low |
| direct_sel | input | 1 | High selects parallel pins for the divider settings |
| pin_m | input | 9 | Parallel main divider value |
| pin_a | input | 4 | Parallel swallow count |
| pin_r | input | 6 | Parallel reference divider value |
| pin_pre_en | input | 1 | Parallel prescaler-enable value |
| fp_in | input | 1 | Divided feedback timing signal |
| msel_in | input | 1 | Prescaler modulus-select signal |
| fc_in | input | 1 | Divided reference timing signal |
| m_val | output | 9 | Active main divider value |
| a_val | output | 4 | Active swallow count |
| r_val | output | 6 | Active reference divider value |
| pre_en | output | 1 | Active prescaler-enable bit |
| pwr_down | output | 1 | Power-down flag |
| cnt_load | output | 1 | Continuous counter-load flag |
| lock_det_off | output | 1 | Lock-detect disable flag |
| dout | output | 1 | Selected timing signal for the data-out pin |

## Verification
The main-word transfer and the control-byte capture are separate events, but a host can release both strobes together, and then they land in the same synchronized cycle. The bench provokes this by loading a main word, then raising the steer strobe and loading a control byte, and then, on a single clock, raising `s_wr` while lowering `e_wr`. After that cycle the divider outputs must carry the new word and the power-down flag must come from the new byte. A second overlap is continuous loading during a shift: the divider outputs are expected to track a word that was shifted in with no strobe at all.

// File: rtl/synth_cfg_port.sv
module synth_cfg_port #(
  parameter int MW   = 9,
  parameter int AW   = 4,
  parameter int RW   = 6,
  parameter int EW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          sdata,
  input  logic          s_wr,
  input  logic          e_wr,
  input  logic          enh_n,
  input  logic          direct_sel,
  input  logic [MW-1:0] pin_m,
  input  logic [AW-1:0] pin_a,
  input  logic [RW-1:0] pin_r,
  input  logic          pin_pre_en,
  input  logic          fp_in,
  input  logic          msel_in,
  input  logic          fc_in,
  output logic [MW-1:0] m_val,
  output logic [AW-1:0] a_val,
  output logic [RW-1:0] r_val,
  output logic          pre_en,
  output logic          pwr_down,
  output logic          cnt_load,
  output logic          lock_det_off,
  output logic          dout
);
  localparam int PW    = MW + AW + RW + 2;
  localparam int SW    = PW - 1;
  localparam int A_LO  = 1;
  localparam int R_LO  = A_LO + AW;
  localparam int M_LO  = R_LO + RW - 2;
  localparam int PRE   = M_LO + MW - 2;
  localparam int B_FP  = 2;
  localparam int B_PD  = 3;
  localparam int B_LD  = 4;
  localparam int B_MS  = 5;
  localparam int B_FC  = 6;
  localparam int B_LDO = 7;

  logic [SYNC:0]   sclk_q, swr_q, ewr_q;
  logic [SYNC-1:0] sd_q;
  logic            sclk_rise, swr_rise, ewr_fall, swr_s, ewr_s, sd_s;
  logic [PW-1:0]   prim;
  logic [SW-1:0]   sec;
  logic [EW-1:0]   esh, esh_rev, ebuf, eff;
  logic [PW-1:0]   w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      swr_q  <= '0;
      ewr_q  <= '0;
      sd_q   <= '0;
    end else begin
      sclk_q <= {sclk_q[SYNC-1:0], sclk};
      swr_q  <= {swr_q[SYNC-1:0], s_wr};
      ewr_q  <= {ewr_q[SYNC-1:0], e_wr};
      sd_q   <= {sd_q[SYNC-2:0], sdata};
    end
  end

  assign sclk_rise = sclk_q[SYNC-1] & ~sclk_q[SYNC];
  assign swr_rise  = swr_q[SYNC-1]  & ~swr_q[SYNC];
  assign ewr_fall  = ~ewr_q[SYNC-1] & ewr_q[SYNC];
  assign swr_s     = swr_q[SYNC-1];
  assign ewr_s     = ewr_q[SYNC-1];
  assign sd_s      = sd_q[SYNC-1];

  for (genvar k = 0; k < EW; k++) begin : g_rev
    assign esh_rev[k] = esh[EW-1-k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim <= '0;
      esh  <= '0;
    end else if (sclk_rise && !swr_s) begin
      if (ewr_s) esh  <= {esh[EW-2:0], sd_s};
      else       prim <= {prim[PW-2:0], sd_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                sec <= '0;
    else if ((swr_rise || cnt_load) && !prim[0]) sec <= prim[PW-1:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ebuf <= '0;
    else if (ewr_fall) ebuf <= esh_rev;
  end

  assign w   = {sec, 1'b0};
  assign eff = enh_n ? '0 : ebuf;

  assign m_val  = direct_sel ? pin_m      : {w[PRE+2], w[PRE+1], w[PRE-1:M_LO]};
  assign r_val  = direct_sel ? pin_r      : {w[PRE+4], w[PRE+3], w[M_LO-1:R_LO]};
  assign a_val  = direct_sel ? pin_a      : w[R_LO-1:A_LO];
  assign pre_en = direct_sel ? pin_pre_en : w[PRE];

  assign pwr_down     = eff[B_PD];
  assign cnt_load     = eff[B_LD];
  assign lock_det_off = eff[B_LDO];
  assign dout = eff[B_FP] ? fp_in :
                eff[B_MS] ? msel_in :
                eff[B_FC] ? fc_in : 1'b0;
endmodule

module synth_cfg_port_chk #(
  parameter int PW = 21,
  parameter int EW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sclk_rise,
  input logic          swr_rise,
  input logic          ewr_fall,
  input logic          swr_s,
  input logic [PW-1:0] prim,
  input logic [PW-2:0] sec,
  input logic [EW-1:0] esh,
  input logic [EW-1:0] ebuf,
  input logic          enh_n,
  input logic          cnt_load,
  input logic          pwr_down,
  input logic          lock_det_off,
  input logic          dout
);
  p_prim_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(prim));
  p_no_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && swr_s) |=> ($stable(prim) && $stable(esh)));
  p_sec_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(swr_rise || cnt_load) |=> $stable(sec));
  p_addr_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((swr_rise || cnt_load) && prim[0]) |=> $stable(sec));
  p_buf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ewr_fall |=> $stable(ebuf));
  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    enh_n |-> !(dout || pwr_down || cnt_load || lock_det_off));
endmodule

bind synth_cfg_port synth_cfg_port_chk #(.PW(PW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .swr_rise(swr_rise),
  .ewr_fall(ewr_fall), .swr_s(swr_s), .prim(prim), .sec(sec), .esh(esh),
  .ebuf(ebuf), .enh_n(enh_n), .cnt_load(cnt_load), .pwr_down(pwr_down),
  .lock_det_off(lock_det_off), .dout(dout)
);

// File: tb/synth_cfg_port_bench.sv
module synth_cfg_port_bench;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, sdata = 0, s_wr = 0, e_wr = 0, enh_n = 1, direct_sel = 0;
  logic [8:0] pin_m = '0;
  logic [3:0] pin_a = '0;
  logic [5:0] pin_r = '0;
  logic pin_pre_en = 0, fp_in = 0, msel_in = 0, fc_in = 0;
  logic [8:0] m_val;
  logic [3:0] a_val;
  logic [5:0] r_val;
  logic pre_en, pwr_down, cnt_load, lock_det_off, dout;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  synth_cfg_port u_synth_cfg_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .s_wr(s_wr),
    .e_wr(e_wr), .enh_n(enh_n), .direct_sel(direct_sel), .pin_m(pin_m),
    .pin_a(pin_a), .pin_r(pin_r), .pin_pre_en(pin_pre_en), .fp_in(fp_in),
    .msel_in(msel_in), .fc_in(fc_in), .m_val(m_val), .a_val(a_val),
    .r_val(r_val), .pre_en(pre_en), .pwr_down(pwr_down), .cnt_load(cnt_load),
    .lock_det_off(lock_det_off), .dout(dout)
  );

  // {m[8:0], a[3:0], r[5:0], pre}
  localparam int NV = 4;
  localparam logic [19:0] VEC [NV] = '{
    {9'h1FF, 4'h0, 6'h00, 1'b0},
    {9'h000, 4'hF, 6'h3F, 1'b1},
    {9'h155, 4'h5, 6'h2A, 1'b0},
    {9'h0AA, 4'hA, 6'h15, 1'b1}
  };

  function automatic logic [20:0] mkword(logic [19:0] v, logic addr);
    logic [8:0] m = v[19:11];
    logic [3:0] a = v[10:7];
    logic [5:0] r = v[6:1];
    return {r[5], r[4], m[8], m[7], v[0], m[6:0], r[3:0], a, addr};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_fields(string req, logic [19:0] v);
    chk(req, "m", m_val, v[19:11]);
    chk(req, "a", a_val, v[10:7]);
    chk(req, "r", r_val, v[6:1]);
    chk(req, "pre", pre_en, v[0]);
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(logic b);
    sdata = b; wait_clk(2);
    sclk = 1;  wait_clk(4);
    sclk = 0;  wait_clk(2);
  endtask

  task automatic send_word(logic [20:0] w);
    for (int i = 20; i >= 0; i--) shift_bit(w[i]);
    wait_clk(4);
  endtask

  task automatic pulse_swr();
    s_wr = 1; wait_clk(6);
    s_wr = 0; wait_clk(6);
  endtask

  task automatic enh_bits(logic [7:0] b);
    e_wr = 1; wait_clk(4);
    for (int k = 0; k < 8; k++) shift_bit(b[k]);
    wait_clk(4);
  endtask

  task automatic send_enh(logic [7:0] b);
    enh_bits(b);
    e_wr = 0; wait_clk(6);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    wait_clk(4);
    chk("R1", "m in reset", m_val, 0);
    rst_n = 1; wait_clk(3);
    chk_fields("R1", 20'h0);
    chk("R1", "dout", dout, 0);
    enh_n = 0; #1;
    chk("R1", "pwr_down", pwr_down, 0);
    chk("R1", "cnt_load", cnt_load, 0);
    enh_n = 1;

    // R2/R3: vector table
    for (int i = 0; i < NV; i++) begin
      send_word(mkword(VEC[i], 1'b0));
      if (i > 0) chk_fields("R3 before strobe", VEC[i-1]);
      pulse_swr();
      chk_fields("R2", VEC[i]);
    end

    // R5: shifting with s_wr high changes nothing
    s_wr = 1; wait_clk(6);
    send_word(mkword(20'h12345, 1'b0));
    s_wr = 0; wait_clk(6);
    pulse_swr();
    chk_fields("R5", VEC[NV-1]);

    // R4: address bit 1 refused
    send_word(mkword(20'hABCDE, 1'b1));
    pulse_swr();
    chk_fields("R4", VEC[NV-1]);

    // R6/R8: bits 3 and 7
    enh_n = 0;
    send_enh(8'h88);
    chk("R8", "pwr_down", pwr_down, 1);
    chk("R8", "lock_det_off", lock_det_off, 1);
    chk("R6", "cnt_load", cnt_load, 0);
    chk("R6", "dout", dout, 0);
    enh_n = 1; #1;
    chk("R7", "pwr_down gated", pwr_down, 0);
    chk("R7", "lock_det_off gated", lock_det_off, 0);
    enh_n = 0;

    // R10: dout priority
    send_enh(8'h64);
    fp_in = 1; msel_in = 0; fc_in = 0; #1;
    chk("R10", "fp first", dout, 1);
    fp_in = 0; msel_in = 1; fc_in = 1; #1;
    chk("R10", "fp over msel", dout, 0);
    send_enh(8'h60);
    msel_in = 0; fc_in = 1; #1;
    chk("R10", "msel over fc", dout, 0);
    msel_in = 1; #1;
    chk("R10", "msel", dout, 1);
    send_enh(8'h40);
    fc_in = 1; #1;
    chk("R10", "fc high", dout, 1);
    fc_in = 0; #1;
    chk("R10", "fc low", dout, 0);
    send_enh(8'h03);
    fp_in = 1; msel_in = 1; fc_in = 1; #1;
    chk("R10", "reserved dout", dout, 0);
    chk("R10", "reserved pwr_down", pwr_down, 0);
    enh_n = 1; #1;
    chk("R7", "dout gated", dout, 0);
    enh_n = 0;

    // R9: continuous load
    send_enh(8'h10);
    chk("R9", "cnt_load", cnt_load, 1);
    send_word(mkword(VEC[1], 1'b0));
    chk_fields("R9", VEC[1]);
    send_enh(8'h00);

    // R11: direct mode
    pin_m = 9'h123; pin_a = 4'h6; pin_r = 6'h1C; pin_pre_en = 1;
    direct_sel = 1; #1;
    chk_fields("R11 direct", {9'h123, 4'h6, 6'h1C, 1'b1});
    direct_sel = 0; #1;
    chk_fields("R11 serial", VEC[1]);

    // R12: simultaneous strobe edges
    send_word(mkword(VEC[2], 1'b0));
    enh_bits(8'h08);
    chk("R12", "pwr_down before", pwr_down, 0);
    s_wr = 1; e_wr = 0; wait_clk(6);
    chk_fields("R12", VEC[2]);
    chk("R12", "pwr_down", pwr_down, 1);
    s_wr = 0; wait_clk(6);

    done = 1;
    summary();
    $finish;
  end
endmodule